// File: doc/BRIEF.md
# Channel Status Change Interrupt Logic

This block watches the per-subframe side bits of a digital audio receiver and raises an interrupt whenever the metadata changes between consecutive blocks. It collects the channel status bit from one channel of each frame, keeps the first 32 of them from each 192-frame block, and compares them with the 32 kept from the previous block. In parallel it assembles an 8-bit track number from the user bits of each 1176-subframe subcode block. In consumer mode, a track number that differs from the previous block's also raises the interrupt.

The interrupt is sticky. It stays high until a read strobe on status register 0 clears it, and the same level appears in bit 5 of that register's value. A one-subframe framing pulse marks the end of every subcode block. The host drives one strobe per subframe, a marker on the first subframe of each channel status block, the two side bits and a consumer-mode flag.

Top module: `cs_change_irq`

## Requirements
- R1: The channel status bit with index j (0 to 31) is the c_bit of the subframe at offset 2j, counting the subframe that carries blk_start as offset 0. When offset 62 is taken, the 32 collected bits are compared with the 32 kept from the previous block. A difference sets irq on that clock edge. C bits at odd offsets or at offsets above 62 have no effect.
- R2: The first channel status block completed after reset only loads the reference word and never sets irq.
- R3: Subcode block timing starts at the first subframe that carries blk_start after reset, and subframes before it are ignored. Blocks then run free over 1176 subframes (offsets 0 to 1175). Later blk_start pulses do not realign them.
- R4: Track bit i (0 to 7) is the u_bit of the subframe at offset 12*(10+i)+2 in the subcode block. At offset 1175 the track is compared with the previous block's, and irq is set only if they differ and consumer is 1 on that subframe. The first subcode block only loads.
- R5: qsync rises on the clock edge of the strobe for offset 1175 and falls on the edge of the next strobe.
- R6: irq is sticky. Without a new change, a cycle with rd_stat0 high clears it on the next edge. It is otherwise held.
- R7: When a change is detected in the same cycle as rd_stat0, irq is set (the set wins).
- R8: stat0 bit 5 equals irq, and every other stat0 bit is 0.
- R9: During and right after reset, irq, qsync and stat0 are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sf_stb | input | 1 | One-cycle strobe per received subframe |
| blk_start | input | 1 | Marks the first subframe of a channel status block (qualified by sf_stb) |
| c_bit | input | 1 | Channel status bit of the strobed subframe |
| u_bit | input | 1 | User bit of the strobed subframe |
| consumer | input | 1 | Consumer-mode flag, enables track comparison |
| rd_stat0 | input | 1 | Read strobe of status register 0, clears irq |
| irq | output | 1 | Sticky change interrupt |
| qsync | output | 1 | Subcode block framing pulse, one subframe long |
| stat0 | output | 8 | Status register 0 value, irq in bit 5 |

## Verification
The stream runs six subcode blocks, which overlap about eighteen channel status blocks, with random C and U bits outside the sampled positions. A mismatch therefore shows whether the block samples the wrong offsets or compares more than 32 bits. The channel status words stay steady across two blocks, then flip bit 0, then bit 31, then bit 15. This separates the first-block load from real changes and tests both ends of the compared window. Track values repeat, change with consumer set, and change with consumer clear, which tells the mode gate apart from the comparison. Reads land on quiet cycles and on the exact cycle of a change, which separates clear-on-read from set-wins.

// File: rtl/cs_change_irq.sv
module cs_change_irq #(
  parameter int CS_BITS = 32,
  parameter int CS_STEP = 2,
  parameter int Q_LEN   = 1176,
  parameter int Q_SYM   = 12,
  parameter int Q_SLOT  = 2,
  parameter int TRK_LO  = 10,
  parameter int TRK_W   = 8,
  parameter int IRQ_BIT = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sf_stb,
  input  logic       blk_start,
  input  logic       c_bit,
  input  logic       u_bit,
  input  logic       consumer,
  input  logic       rd_stat0,
  output logic       irq,
  output logic       qsync,
  output logic [7:0] stat0
);
  localparam int CS_LAST = (CS_BITS - 1) * CS_STEP;
  localparam int CW = $clog2(CS_LAST + 2);
  localparam int QW = $clog2(Q_LEN);
  localparam int IW = $clog2(CS_BITS);

  logic [CW-1:0]      cs_cnt, cs_pos;
  logic [CS_BITS-1:0] cs_sh, cs_ref, cs_new;
  logic               cs_ok, cs_take, cs_done, cs_chg;
  logic [QW-1:0]      q_cnt, q_pos;
  logic               q_run, q_act, q_end, q_ok, q_chg;
  logic [TRK_W-1:0]   trk_sh, trk_ref;

  assign cs_pos  = blk_start ? '0 : cs_cnt;
  assign cs_take = sf_stb && (int'(cs_pos) <= CS_LAST) && (int'(cs_pos) % CS_STEP == 0);
  assign cs_done = cs_take && (int'(cs_pos) == CS_LAST);
  assign cs_new  = {c_bit, cs_sh[CS_BITS-2:0]};
  assign cs_chg  = cs_done && cs_ok && (cs_new != cs_ref);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_cnt <= CW'(CS_LAST + 1);
      cs_sh  <= '0;
      cs_ref <= '0;
      cs_ok  <= 1'b0;
    end else if (sf_stb) begin
      cs_cnt <= (int'(cs_pos) <= CS_LAST) ? cs_pos + 1'b1 : cs_pos;
      if (cs_take) cs_sh[IW'(int'(cs_pos) / CS_STEP)] <= c_bit;
      if (cs_done) begin
        cs_ref <= cs_new;
        cs_ok  <= 1'b1;
      end
    end
  end

  assign q_act = sf_stb && (q_run || blk_start);
  assign q_pos = q_run ? q_cnt : '0;
  assign q_end = q_act && (int'(q_pos) == Q_LEN - 1);
  assign q_chg = q_end && q_ok && consumer && (trk_sh != trk_ref);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_run   <= 1'b0;
      q_cnt   <= '0;
      q_ok    <= 1'b0;
      trk_sh  <= '0;
      trk_ref <= '0;
      qsync   <= 1'b0;
    end else begin
      if (q_act) begin
        q_run <= 1'b1;
        q_cnt <= q_end ? '0 : q_pos + 1'b1;
        for (int i = 0; i < TRK_W; i++)
          if (int'(q_pos) == Q_SYM * (TRK_LO + i) + Q_SLOT) trk_sh[i] <= u_bit;
        if (q_end) begin
          trk_ref <= trk_sh;
          q_ok    <= 1'b1;
        end
      end
      if (sf_stb) qsync <= q_end;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= cs_chg | q_chg | (irq & ~rd_stat0);
  end

  always_comb begin
    stat0 = '0;
    stat0[IRQ_BIT] = irq;
  end

  p_qsync_rise_r5: assert property (@(posedge clk) disable iff (!rst_n) q_end |=> qsync);
  p_qsync_fall_r5: assert property (@(posedge clk) disable iff (!rst_n) (sf_stb && !q_end) |=> !qsync);
  p_irq_hold_r6:   assert property (@(posedge clk) disable iff (!rst_n) (irq && !rd_stat0) |=> irq);
  p_irq_quiet_r6:  assert property (@(posedge clk) disable iff (!rst_n) (!irq && !cs_chg && !q_chg) |=> !irq);
  p_set_wins_r7:   assert property (@(posedge clk) disable iff (!rst_n) (cs_chg || q_chg) |=> irq);
  p_q_wrap_r3:     assert property (@(posedge clk) disable iff (!rst_n) q_end |=> (q_cnt == '0));
endmodule

// File: tb/sim_cs_change_irq.sv
module sim_cs_change_irq;
  localparam int PER = 10;
  localparam int NQ  = 6;

  logic clk = 1'b0;
  always #(PER / 2) clk = ~clk;

  logic rst_n, sf_stb, blk_start, c_bit, u_bit, consumer, rd_stat0;
  logic irq, qsync;
  logic [7:0] stat0;

  cs_change_irq u0 (.clk, .rst_n, .sf_stb, .blk_start, .c_bit, .u_bit,
                    .consumer, .rd_stat0, .irq, .qsync, .stat0);

  int checks = 0, errors = 0;
  string tag = "R9";
  logic [15:0] lf = 16'hACE1;

  int  m_cs_next = 1000;
  bit  m_cs_cur[32], m_cs_ref[32];
  bit  m_cs_ok = 0;
  bit  m_q_run = 0, m_q_ok = 0;
  int  m_q_idx = 0;
  bit  m_trk[8], m_trk_ref[8];
  bit  m_irq = 0, m_qs = 0;

  task automatic rnd(output bit b);
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    b = lf[0];
  endtask

  function automatic logic [31:0] csw(int b);
    logic [31:0] w = 32'h1234_5678;
    if (b >= 2) w ^= 32'h0000_0001;
    if (b >= 3) w ^= 32'h8000_0000;
    if (b >= 8) w ^= 32'h0000_8000;
    return w;
  endfunction

  function automatic logic [7:0] trk_of(int qb);
    if (qb < 2) return 8'd5;
    if (qb == 2) return 8'd6;
    if (qb < 5) return 8'd9;
    return 8'h80;
  endfunction

  task automatic model(input bit sf, blk, c, u, cons, rd);
    bit set = 0, diff, qend = 0;
    int pos, qp;
    if (sf) begin
      pos = blk ? 0 : m_cs_next;
      if (pos <= 62 && pos % 2 == 0) begin
        m_cs_cur[pos / 2] = c;
        if (pos == 62) begin
          diff = 0;
          for (int j = 0; j < 32; j++) if (m_cs_cur[j] != m_cs_ref[j]) diff = 1;
          if (m_cs_ok && diff) set = 1;
          tag = m_cs_ok ? "R1" : "R2";
          m_cs_ref = m_cs_cur;
          m_cs_ok = 1;
        end
      end
      m_cs_next = (pos <= 62) ? pos + 1 : pos;
      if (m_q_run || blk) begin
        qp = m_q_run ? m_q_idx : 0;
        m_q_run = 1;
        for (int i = 0; i < 8; i++) if (qp == 12 * (10 + i) + 2) m_trk[i] = u;
        qend = (qp == 1175);
        if (qend) begin
          diff = 0;
          for (int i = 0; i < 8; i++) if (m_trk[i] != m_trk_ref[i]) diff = 1;
          if (m_q_ok && cons && diff) set = 1;
          tag = m_q_ok ? "R4" : "R3";
          m_trk_ref = m_trk;
          m_q_ok = 1;
        end
        m_q_idx = qend ? 0 : qp + 1;
      end
      m_qs = qend;
    end
    if (rd) tag = set ? "R7" : "R6";
    m_irq = set | (m_irq & !rd);
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare();
    check(tag, {7'd0, irq}, {7'd0, m_irq});
    check("R5", {7'd0, qsync}, {7'd0, m_qs});
    check("R8", stat0, {2'b00, m_irq, 5'b00000});
  endtask

  task automatic step(input bit sf, blk, c, u, cons, rd);
    sf_stb = sf; blk_start = blk; c_bit = c; u_bit = u; consumer = cons; rd_stat0 = rd;
    @(posedge clk);
    model(sf, blk, c, u, cons, rd);
    @(negedge clk);
    compare();
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(PER * 200000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    bit r1, r2;
    logic [31:0] w;
    logic [7:0] t;
    rst_n = 0; sf_stb = 0; blk_start = 0; c_bit = 0; u_bit = 0; consumer = 0; rd_stat0 = 0;
    repeat (3) @(negedge clk);
    check("R9", {6'd0, irq, qsync}, 8'd0);
    check("R9", stat0, 8'd0);
    rst_n = 1;
    @(negedge clk);
    check("R9", {6'd0, irq, qsync}, 8'd0);
    // R3: strobes before the first block marker are ignored
    for (int k = 0; k < 5; k++) begin
      rnd(r1); rnd(r2);
      step(1, 0, r1, r2, 1, 0);
      step(0, 0, 0, 0, 1, 0);
    end
    for (int g = 0; g < NQ * 1176; g++) begin
      int qb = g / 1176, s = g % 1176, b = g / 384, p = g % 384;
      bit c, u, cons, rdp;
      w = csw(b);
      t = trk_of(qb);
      cons = (qb != 3);
      rnd(c); rnd(u); rnd(rdp);
      if (p % 2 == 0 && p <= 62) c = w[p / 2];
      for (int i = 0; i < 8; i++) if (s == 12 * (10 + i) + 2) u = t[i];
      // R7: read on the very cycle of the bit-31 change
      step(1, p == 0, c, u, cons, (b == 3 && p == 62));
      // R6: reads on quiet cycles
      step(0, 0, 0, 0, cons, (p == 100) || (rdp && (lf[3:0] == 4'd7)));
    end
    repeat (4) step(0, 0, 0, 0, 1, 1);
    check("R6", {7'd0, irq}, 8'd0);
    finish_run();
  end
endmodule